// File: doc/BRIEF.md
# Joinable transmit/receive FIFO pair

This block holds the word queues that sit between the system bus and one programmable I/O engine. Transmit words arrive from the system and wait until the engine takes them. Receive words arrive from the engine and wait until the system reads them. All entries live in one shared storage array. By default the array is split into two independent queues of `HALF_DEPTH` entries each.

A two-bit join selector can give the whole array to one direction, so that queue becomes twice as deep. The queue left with no storage then has zero capacity and shows full and empty at the same time. Whenever the decoded join mode changes, both queues are emptied.

On the engine side, an accepted pull moves exactly one word into an output word register. A pull from an empty transmit queue, or a push into a full receive queue, raises a stall output. The engine holds its request until the stall clears.

Top module: `joinable_fifo_pair`

## Requirements
- R1: After synchronous reset both queues are empty and not full, the mode is split, `eng_osr` is 0, and both sticky flags are 0.
- R2: In split mode (join_sel 2'b00) each queue holds exactly HALF_DEPTH (4) words. Words leave each queue in the order they entered, and full rises on the 4th stored word.
- R3: join_sel 2'b01 gives the transmit queue 2*HALF_DEPTH (8) entries. join_sel 2'b10 gives the receive queue 8 entries. join_sel 2'b11 behaves as 2'b00.
- R4: The queue left without storage (receive under 2'b01, transmit under 2'b10) has both its full and empty outputs at 1.
- R5: `eng_push_stall` equals `eng_push_req` while the receive queue is full, including at zero capacity. A stalled push stores nothing.
- R6: In the cycle where the decoded join mode differs from the current mode, all other operations are ignored. From the next cycle both queues are empty at the new capacities. A raw change that decodes to the same mode (2'b00 to 2'b11) keeps all data.
- R7: A pull with the transmit queue not empty loads the head word into `eng_osr` at the clock edge and removes exactly one word. A pull from an empty transmit queue raises `eng_pull_stall`. `eng_osr` keeps its value in every cycle without an accepted pull.
- R8: A system write to a full transmit queue is dropped and sets `tx_overflow`, which stays at 1 until reset.
- R9: A system read of an empty receive queue shows `sys_rd_data` = 0 and sets `rx_underflow`, which stays at 1 until reset. Otherwise `sys_rd_data` shows the head word during the read cycle.
- R10: A push and a pop on the same queue in the same cycle, while it is neither empty nor full, both take effect and leave its fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| join_sel | input | 2 | Join selector: 00/11 split, 01 transmit-deep, 10 receive-deep |
| sys_wr_en | input | 1 | System write into the transmit queue |
| sys_wr_data | input | WIDTH | Word written by the system |
| sys_rd_en | input | 1 | System read (pop) of the receive queue |
| sys_rd_data | output | WIDTH | Receive head word, 0 when the queue is empty |
| eng_pull_req | input | 1 | Engine request to take a transmit word |
| eng_osr | output | WIDTH | Engine output word register |
| eng_pull_stall | output | 1 | Pull requested while the transmit queue is empty |
| eng_push_req | input | 1 | Engine request to store a receive word |
| eng_push_data | input | WIDTH | Word pushed by the engine |
| eng_push_stall | output | 1 | Push requested while the receive queue is full |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_overflow | output | 1 | Sticky: a write was dropped |
| rx_underflow | output | 1 | Sticky: a read found the queue empty |

## Verification
Two operations can fall in the same cycle: a system write together with an engine pull on the transmit queue, and an engine push together with a system read on the receive queue. The bench first part-fills a queue, then issues both operations in one cycle. It checks that the pulled or read word is the old head and that the following fill and drain reach full at the count a reference queue model predicts. A second collision is a join change issued with data still held. It is judged by empty flags in the next cycle, a stalled pull, and a zero read with underflow.

// File: rtl/jfp_pkg.sv
package jfp_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT = 2'd0,
        MODE_TXDEEP = 2'd1,
        MODE_RXDEEP = 2'd2
    } mode_e;

    // both bits set is treated as the split mode
    function automatic mode_e decode_join(input logic [1:0] sel);
        case (sel)
            2'b01:   return MODE_TXDEEP;
            2'b10:   return MODE_RXDEEP;
            default: return MODE_SPLIT;
        endcase
    endfunction

    typedef struct packed {
        logic full;
        logic empty;
    } qflags_t;

endpackage

// File: rtl/jfp_ring_ctrl.sv
module jfp_ring_ctrl #(
    parameter int TOTAL = 8,
    localparam int AW = $clog2(TOTAL),
    localparam int CW = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic          pop,
    output logic          push_acc,
    output logic          pop_acc,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output jfp_pkg::qflags_t flags
);

    logic [CW-1:0] level;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input logic [CW-1:0] c);
        if (CW'(p) + CW'(1) >= c) return '0;
        return p + AW'(1);
    endfunction

    assign flags.full  = (level == cap);
    assign flags.empty = (level == '0);
    assign push_acc    = push && !flags.full && !flush;
    assign pop_acc     = pop && !flags.empty && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level  <= '0;
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push_acc) wr_idx <= advance(wr_idx, cap);
            if (pop_acc)  rd_idx <= advance(rd_idx, cap);
            level <= level + CW'(push_acc) - CW'(pop_acc);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) level <= cap); // R2
    AST_SAME_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (push_acc && pop_acc) |=> $stable(level)); // R10
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cap != '0) |-> (CW'(rd_idx) < cap && CW'(wr_idx) < cap)); // R3

endmodule

// File: rtl/jfp_store.sv
module jfp_store #(
    parameter int WIDTH = 32,
    parameter int TOTAL = 8,
    localparam int AW = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_a,
    input  logic [AW-1:0]    wa_a,
    input  logic [WIDTH-1:0] wd_a,
    input  logic             we_b,
    input  logic [AW-1:0]    wa_b,
    input  logic [WIDTH-1:0] wd_b,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);

    logic [WIDTH-1:0] cells [TOTAL];

    always_ff @(posedge clk) begin
        if (we_a) cells[wa_a] <= wd_a;
        if (we_b) cells[wa_b] <= wd_b;
    end

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];

    AST_PORT_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(we_a && we_b && wa_a == wa_b)); // R3

endmodule

// File: rtl/joinable_fifo_pair.sv
module joinable_fifo_pair #(
    parameter int WIDTH = 32,
    parameter int HALF_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       join_sel,
    input  logic             sys_wr_en,
    input  logic [WIDTH-1:0] sys_wr_data,
    input  logic             sys_rd_en,
    output logic [WIDTH-1:0] sys_rd_data,
    input  logic             eng_pull_req,
    output logic [WIDTH-1:0] eng_osr,
    output logic             eng_pull_stall,
    input  logic             eng_push_req,
    input  logic [WIDTH-1:0] eng_push_data,
    output logic             eng_push_stall,
    output logic             tx_full,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             rx_empty,
    output logic             tx_overflow,
    output logic             rx_underflow
);
    import jfp_pkg::*;

    localparam int TOTAL = 2 * HALF_DEPTH;
    localparam int AW = $clog2(TOTAL);
    localparam int CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] CAP_HALF = CW'(HALF_DEPTH);
    localparam logic [CW-1:0] CAP_ALL  = CW'(TOTAL);

    mode_e mode_q, mode_d;
    logic  chg;
    logic [CW-1:0] tx_cap, rx_cap;
    logic [AW-1:0] rx_base;
    logic [AW-1:0] tx_wi, tx_ri, rx_wi, rx_ri;
    logic tx_push_acc, tx_pop_acc, rx_push_acc, rx_pop_acc;
    logic [WIDTH-1:0] tx_head, rx_head;
    qflags_t tx_fl, rx_fl;

    assign mode_d = decode_join(join_sel);
    assign chg    = (mode_d != mode_q);

    always_comb begin
        unique case (mode_q)
            MODE_TXDEEP: begin tx_cap = CAP_ALL;  rx_cap = '0;       rx_base = '0; end
            MODE_RXDEEP: begin tx_cap = '0;       rx_cap = CAP_ALL;  rx_base = '0; end
            default:     begin tx_cap = CAP_HALF; rx_cap = CAP_HALF; rx_base = AW'(HALF_DEPTH); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SPLIT;
        else     mode_q <= mode_d;
    end

    jfp_ring_ctrl #(.TOTAL(TOTAL)) u_tx_ctrl (
        .clk(clk), .rst(rst), .flush(chg), .cap(tx_cap),
        .push(sys_wr_en), .pop(eng_pull_req),
        .push_acc(tx_push_acc), .pop_acc(tx_pop_acc),
        .wr_idx(tx_wi), .rd_idx(tx_ri), .flags(tx_fl)
    );

    jfp_ring_ctrl #(.TOTAL(TOTAL)) u_rx_ctrl (
        .clk(clk), .rst(rst), .flush(chg), .cap(rx_cap),
        .push(eng_push_req), .pop(sys_rd_en),
        .push_acc(rx_push_acc), .pop_acc(rx_pop_acc),
        .wr_idx(rx_wi), .rd_idx(rx_ri), .flags(rx_fl)
    );

    jfp_store #(.WIDTH(WIDTH), .TOTAL(TOTAL)) u_store (
        .clk(clk), .rst(rst),
        .we_a(tx_push_acc), .wa_a(tx_wi), .wd_a(sys_wr_data),
        .we_b(rx_push_acc), .wa_b(rx_base + rx_wi), .wd_b(eng_push_data),
        .ra_a(tx_ri), .ra_b(rx_base + rx_ri),
        .rd_a(tx_head), .rd_b(rx_head)
    );

    assign tx_full  = tx_fl.full;
    assign tx_empty = tx_fl.empty;
    assign rx_full  = rx_fl.full;
    assign rx_empty = rx_fl.empty;

    assign sys_rd_data    = rx_fl.empty ? '0 : rx_head;
    assign eng_pull_stall = eng_pull_req && tx_fl.empty;
    assign eng_push_stall = eng_push_req && rx_fl.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_osr      <= '0;
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            if (tx_pop_acc) eng_osr <= tx_head;
            if (sys_wr_en && tx_fl.full && !chg) tx_overflow <= 1'b1;
            if (sys_rd_en && rx_fl.empty && !chg) rx_underflow <= 1'b1;
        end
    end

    AST_STALL_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        eng_push_stall |-> !rx_push_acc); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        chg |=> (tx_empty && rx_empty)); // R6
    AST_ZERO_CAP_RX: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TXDEEP) |-> (rx_full && rx_empty)); // R4
    AST_ZERO_CAP_TX: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RXDEEP) |-> (tx_full && tx_empty)); // R4
    AST_OSR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_pop_acc |=> $stable(eng_osr)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(tx_overflow) |-> tx_overflow); // R8
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(rx_underflow) |-> rx_underflow); // R9

endmodule

// File: tb/test_joinable_fifo_pair.sv
`timescale 1ns/1ps
module test_joinable_fifo_pair;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] join_sel = 2'b00;
    logic sys_wr_en = 1'b0, sys_rd_en = 1'b0, eng_pull_req = 1'b0, eng_push_req = 1'b0;
    logic [W-1:0] sys_wr_data = '0, eng_push_data = '0;
    logic [W-1:0] sys_rd_data, eng_osr;
    logic eng_pull_stall, eng_push_stall, tx_full, tx_empty, rx_full, rx_empty;
    logic tx_overflow, rx_underflow;

    always #2 clk = ~clk;

    joinable_fifo_pair #(.WIDTH(W), .HALF_DEPTH(4)) i_joinable_fifo_pair (
        .clk(clk), .rst(rst), .join_sel(join_sel),
        .sys_wr_en(sys_wr_en), .sys_wr_data(sys_wr_data),
        .sys_rd_en(sys_rd_en), .sys_rd_data(sys_rd_data),
        .eng_pull_req(eng_pull_req), .eng_osr(eng_osr), .eng_pull_stall(eng_pull_stall),
        .eng_push_req(eng_push_req), .eng_push_data(eng_push_data), .eng_push_stall(eng_push_stall),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    int n_total = 0;
    int n_bad = 0;
    logic [W-1:0] tq[$];
    logic [W-1:0] rq[$];
    logic [W-1:0] exp_osr_q[$];
    logic pull_armed = 1'b0;
    logic [W-1:0] m_osr = '0;
    logic m_ovf = 1'b0, m_unf = 1'b0;
    logic [1:0] cur_js = 2'b00;
    jfp_pkg::mode_e m_mode = jfp_pkg::MODE_SPLIT;

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int tcap(input jfp_pkg::mode_e m);
        return (m == jfp_pkg::MODE_TXDEEP) ? 8 : (m == jfp_pkg::MODE_RXDEEP) ? 0 : 4;
    endfunction
    function automatic int rcap(input jfp_pkg::mode_e m);
        return (m == jfp_pkg::MODE_RXDEEP) ? 8 : (m == jfp_pkg::MODE_TXDEEP) ? 0 : 4;
    endfunction
    function automatic jfp_pkg::mode_e mdec(input logic [1:0] s);
        return (s == 2'b01) ? jfp_pkg::MODE_TXDEEP : (s == 2'b10) ? jfp_pkg::MODE_RXDEEP : jfp_pkg::MODE_SPLIT;
    endfunction

    task automatic step(input string tag, input logic wr, input logic [W-1:0] wd, input logic rd,
                        input logic pl, input logic ps, input logic [W-1:0] pd, input logic [1:0] js);
        jfp_pkg::mode_e nm;
        logic tf, te, rf, re;
        @(negedge clk);
        sys_wr_en = wr; sys_wr_data = wd; sys_rd_en = rd;
        eng_pull_req = pl; eng_push_req = ps; eng_push_data = pd; join_sel = js;
        cur_js = js;
        #1;
        nm = mdec(js);
        if (nm == m_mode) begin
            tf = (tq.size() == tcap(m_mode)); te = (tq.size() == 0);
            rf = (rq.size() == rcap(m_mode)); re = (rq.size() == 0);
            if (pl) check(tag, "pull stall", W'(eng_pull_stall), W'(te));
            if (ps) check(tag, "push stall", W'(eng_push_stall), W'(rf));
            if (rd) check(tag, "read data", sys_rd_data, re ? '0 : rq[0]);
            if (pl && !te) begin exp_osr_q.push_back(tq.pop_front()); pull_armed = 1'b1; end
            if (wr) begin if (!tf) tq.push_back(wd); else m_ovf = 1'b1; end
            if (rd) begin if (!re) void'(rq.pop_front()); else m_unf = 1'b1; end
            if (ps && !rf) rq.push_back(pd);
        end else begin
            tq.delete(); rq.delete(); m_mode = nm;
        end
        @(posedge clk);
        #1;
        sys_wr_en = 0; sys_rd_en = 0; eng_pull_req = 0; eng_push_req = 0;
        check(tag, "tx_full", W'(tx_full), W'(tq.size() == tcap(m_mode)));
        check(tag, "tx_empty", W'(tx_empty), W'(tq.size() == 0));
        check(tag, "rx_full", W'(rx_full), W'(rq.size() == rcap(m_mode)));
        check(tag, "rx_empty", W'(rx_empty), W'(rq.size() == 0));
        check(tag, "tx_overflow", W'(tx_overflow), W'(m_ovf));
        check(tag, "rx_underflow", W'(rx_underflow), W'(m_unf));
    endtask

    task automatic wr(input string tag, input logic [W-1:0] d); step(tag, 1, d, 0, 0, 0, '0, cur_js); endtask
    task automatic rd(input string tag); step(tag, 0, '0, 1, 0, 0, '0, cur_js); endtask
    task automatic pull(input string tag); step(tag, 0, '0, 0, 1, 0, '0, cur_js); endtask
    task automatic push(input string tag, input logic [W-1:0] d); step(tag, 0, '0, 0, 0, 1, d, cur_js); endtask
    task automatic setjoin(input string tag, input logic [1:0] js); step(tag, 0, '0, 0, 0, 0, '0, js); endtask

    // monitor: compares the engine word register against the scoreboard
    always @(posedge clk) begin
        #1;
        if (pull_armed) begin
            m_osr = exp_osr_q.pop_front();
            pull_armed = 1'b0;
            check("R7", "osr load", eng_osr, m_osr);
        end else if (!rst) begin
            check("R7", "osr hold", eng_osr, m_osr);
        end
    end

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL all: watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "tx_empty", W'(tx_empty), 1); check("R1", "tx_full", W'(tx_full), 0);
        check("R1", "rx_empty", W'(rx_empty), 1); check("R1", "rx_full", W'(rx_full), 0);
        check("R1", "osr", eng_osr, 0);
        check("R1", "sticky", W'({tx_overflow, rx_underflow}), 0);

        for (int i = 0; i < 4; i++) wr("R2", 32'hA000_0000 + i);
        wr("R8", 32'hDEAD_0001);
        for (int i = 0; i < 4; i++) pull("R7");
        pull("R7");

        for (int i = 0; i < 4; i++) push("R2", 32'hB000_0000 + i);
        push("R5", 32'hDEAD_0002);
        for (int i = 0; i < 4; i++) rd("R2");
        rd("R9");

        wr("R6", 32'hC000_0000); wr("R6", 32'hC000_0001);
        setjoin("R6", 2'b11);
        pull("R6"); pull("R6");

        setjoin("R6", 2'b01);
        push("R4", 32'hDEAD_0003);
        rd("R4");
        for (int i = 0; i < 8; i++) wr("R3", 32'hD000_0000 + i);
        wr("R8", 32'hDEAD_0004);
        for (int i = 0; i < 8; i++) pull("R3");

        wr("R6", 32'hE000_0000); wr("R6", 32'hE000_0001); wr("R6", 32'hE000_0002);
        setjoin("R6", 2'b10);
        pull("R4");
        wr("R4", 32'hDEAD_0005);
        for (int i = 0; i < 8; i++) push("R3", 32'hF000_0000 + i);
        push("R5", 32'hDEAD_0006);
        for (int i = 0; i < 6; i++) rd("R3");
        setjoin("R6", 2'b11);
        rd("R6");

        for (int i = 0; i < 4; i++) wr("R3", 32'h1100_0000 + i);
        wr("R3", 32'hDEAD_0007);
        for (int i = 0; i < 4; i++) pull("R3");

        wr("R10", 32'h2200_0000); wr("R10", 32'h2200_0001);
        step("R10", 1, 32'h2200_0002, 0, 1, 0, '0, cur_js);
        wr("R10", 32'h2200_0003); wr("R10", 32'h2200_0004);
        wr("R10", 32'hDEAD_0008);
        for (int i = 0; i < 4; i++) pull("R10");
        push("R10", 32'h3300_0000); push("R10", 32'h3300_0001);
        step("R10", 0, '0, 1, 0, 1, 32'h3300_0002, cur_js);
        push("R10", 32'h3300_0003); push("R10", 32'h3300_0004);
        push("R10", 32'hDEAD_0009);
        for (int i = 0; i < 5; i++) rd("R10");

        repeat (2) @(posedge clk);
        #1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule